// File: doc/BRIEF.md
# Two-Level Data Address Translation Unit

The unit translates a data virtual address plus a context number into a physical address. A lookup is first compared against a small, fully associative micro-TLB. When the micro-TLB hits, the translation is returned on the next cycle and nothing else is searched. When it misses, the request moves one stage on and searches the main TLB in the following cycle. The main TLB has two parts: a fully associative part for locked entries and large pages, and a two-way set-associative part for small unlocked pages.

A single hit in the main TLB is returned and copied into the micro-TLB. Several matching entries in the main TLB give a multi-hit error. No match at all gives a miss. Entries are installed through a write port. The lock bit and the page size of each entry choose which part it goes into. Every write also removes any micro-TLB copy of the same virtual page. The unit supports 8 KB and 4 MB pages. Physical addresses are 43 bits wide and are carried in a 47-bit field.

Top module: `xlt_unit`

## Requirements
- R1: After reset, no translation is held, `lk_rdy_o` is 1, `rsp_vld_o` is 0 and `fa_ovf_o` is 0. A first lookup reports a miss.
- R2: A lookup that hits in the micro-TLB is answered in the cycle after it is accepted, with `rsp_hit_o`. `lk_rdy_o` stays high during that cycle.
- R3: A lookup that misses in the micro-TLB drops `lk_rdy_o` for one cycle and is answered one cycle later than a micro-TLB hit. If exactly one main-TLB entry matches, the answer is a hit and the entry is copied into the micro-TLB, so the next lookup of that page is answered in one cycle.
- R4: A lookup that matches nothing in either level returns `rsp_miss_o`, a zero physical address and no refill. A repeated lookup again takes two cycles. On a valid response exactly one of hit, miss and multi-hit is set.
- R5: A micro-TLB miss that matches two or more main-TLB entries, in either part or across both parts, returns `rsp_mhit_o` with a zero address. The result is not copied into the micro-TLB.
- R6: A lookup that hits in the micro-TLB is not checked against the main TLB. It returns its hit even if the main TLB holds several matches for that address.
- R7: Every write removes each micro-TLB entry whose own page, 8 KB or 4 MB, contains the written virtual address. The next lookup of that page searches the main TLB again.
- R8: A write with `wr_lock_i`=1 goes into the fully associative part whatever its size. An unlocked write with `wr_big_i`=1 (4 MB) also goes into the fully associative part. An unlocked write with `wr_big_i`=0 (8 KB) goes into the set-associative part, with the set given by virtual address bits 16:13.
- R9: An unlocked write into the full fully associative part replaces the oldest unlocked entry. Locked entries are never replaced.
- R10: A write meant for the fully associative part while all 8 of its entries are locked is dropped. It sets `fa_ovf_o`, which stays at 1 until reset.
- R11: The response address is the page number of the entry followed by the page offset of the lookup address: bits 12:0 for 8 KB pages and bits 21:0 for 4 MB pages. Bits 46:43 of `rsp_pa_o` are always 0. Bits 46:43 of `wr_pa_i` are ignored.
- R12: In the set-associative part, a write goes to an empty way of its set if one exists. Otherwise it takes a way chosen by a per-set round-robin pointer that starts at way 0.
- R13: An entry matches only a lookup with the same context number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_req_i | input | 1 | Lookup request |
| lk_va_i | input | 44 | Lookup virtual address |
| lk_ctx_i | input | 13 | Lookup context |
| lk_rdy_o | output | 1 | Lookup can be accepted |
| wr_en_i | input | 1 | Install a translation |
| wr_va_i | input | 44 | Virtual address of the entry |
| wr_ctx_i | input | 13 | Context of the entry |
| wr_pa_i | input | 47 | Physical address field; bits 46:43 ignored |
| wr_big_i | input | 1 | Page size: 1 = 4 MB, 0 = 8 KB |
| wr_lock_i | input | 1 | Lock the entry |
| rsp_vld_o | output | 1 | Response valid |
| rsp_hit_o | output | 1 | Translation found |
| rsp_miss_o | output | 1 | No translation found |
| rsp_mhit_o | output | 1 | Multi-hit error |
| rsp_pa_o | output | 47 | Physical address |
| fa_ovf_o | output | 1 | Sticky: a write was dropped because every fully associative entry was locked |

## Verification
A micro-TLB hit is answered on the first falling edge after the accepting rising edge. A micro-TLB miss shows `lk_rdy_o` low at that edge and is answered on the next falling edge. The bench samples both points and records which one carried the response. It compares that latency with the one predicted from its own record of which pages the micro-TLB must hold. A write takes effect at the rising edge inside its write task, so every lookup that follows sees it.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
  localparam int VA_W       = 44;
  localparam int CTX_W      = 13;
  localparam int PA_W       = 43;
  localparam int PA_FIELD_W = 47;
  localparam int SMALL_SH   = 13;
  localparam int LARGE_SH   = 22;
  localparam int VPN_W      = VA_W - SMALL_SH;
  localparam int PPN_W      = PA_W - SMALL_SH;
  localparam int SUB_W      = LARGE_SH - SMALL_SH;

  typedef struct packed {
    logic             vld;
    logic             lck;
    logic             big;
    logic [CTX_W-1:0] ctx;
    logic [VPN_W-1:0] vpn;
    logic [PPN_W-1:0] ppn;
  } tte_t;

  function automatic logic [VPN_W-1:0] page_mask(input logic big);
    return big ? {{(VPN_W-SUB_W){1'b1}}, {SUB_W{1'b0}}} : {VPN_W{1'b1}};
  endfunction

  function automatic logic page_hit(input tte_t e, input logic [VPN_W-1:0] vpn);
    return e.vld && (((e.vpn ^ vpn) & page_mask(e.big)) == '0);
  endfunction

  function automatic logic tte_match(input tte_t e, input logic [VPN_W-1:0] vpn,
                                     input logic [CTX_W-1:0] ctx);
    return page_hit(e, vpn) && (e.ctx == ctx);
  endfunction

  function automatic logic [PA_FIELD_W-1:0] mk_pa(input tte_t e, input logic [VA_W-1:0] va);
    logic [PPN_W-1:0] ppn;
    ppn = e.big ? {e.ppn[PPN_W-1:SUB_W], va[LARGE_SH-1:SMALL_SH]} : e.ppn;
    return {{(PA_FIELD_W-PA_W){1'b0}}, ppn, va[SMALL_SH-1:0]};
  endfunction
endpackage

// File: rtl/xlt_utlb.sv
module xlt_utlb
  import xlt_pkg::*;
#(
  parameter int N = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VPN_W-1:0] lk_vpn_i,
  input  logic [CTX_W-1:0] lk_ctx_i,
  output logic             hit_o,
  output tte_t             hit_tte_o,
  input  logic             fill_i,
  input  tte_t             fill_tte_i,
  input  logic             inv_i,
  input  logic [VPN_W-1:0] inv_vpn_i
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  tte_t          ent_q [N];
  logic [PW-1:0] rr_q;

  always_comb begin
    hit_o     = 1'b0;
    hit_tte_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (tte_match(ent_q[i], lk_vpn_i, lk_ctx_i)) begin
        hit_o     = 1'b1;
        hit_tte_o = ent_q[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) ent_q[i] <= '0;
      rr_q <= '0;
    end else begin
      for (int i = 0; i < N; i++)
        if (inv_i && page_hit(ent_q[i], inv_vpn_i)) ent_q[i].vld <= 1'b0;
      if (fill_i) begin
        ent_q[rr_q] <= fill_tte_i;
        rr_q        <= (rr_q == PW'(N - 1)) ? '0 : rr_q + 1'b1;
      end
    end
  end

  // invalidation check
  logic             inv_q;
  logic [VPN_W-1:0] inv_vpn_q;
  logic             stale;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inv_q     <= 1'b0;
      inv_vpn_q <= '0;
    end else begin
      inv_q     <= inv_i;
      inv_vpn_q <= inv_vpn_i;
    end
  end
  always_comb begin
    stale = 1'b0;
    for (int i = 0; i < N; i++) stale |= page_hit(ent_q[i], inv_vpn_q);
  end

  p_inv_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_q |-> !stale);
endmodule

// File: rtl/xlt_fa.sv
module xlt_fa
  import xlt_pkg::*;
#(
  parameter int N = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VPN_W-1:0] lk_vpn_i,
  input  logic [CTX_W-1:0] lk_ctx_i,
  output logic             hit_o,
  output logic             multi_o,
  output tte_t             hit_tte_o,
  input  logic             wr_i,
  input  tte_t             wr_tte_i,
  output logic             ovf_o
);
  localparam int AW = (N > 1) ? $clog2(N) : 1;

  tte_t          ent_q [N];
  logic [AW-1:0] age_q [N];
  logic          ovf_q;

  int            cnt;
  logic          free_ok, vic_ok, do_wr;
  logic [AW-1:0] free_idx, vic_idx, vic_age, tgt;

  always_comb begin
    cnt       = 0;
    hit_tte_o = '0;
    for (int i = 0; i < N; i++) begin
      if (tte_match(ent_q[i], lk_vpn_i, lk_ctx_i)) begin
        cnt++;
        hit_tte_o = ent_q[i];
      end
    end
    hit_o   = (cnt > 0);
    multi_o = (cnt > 1);
  end

  always_comb begin
    free_ok  = 1'b0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (!ent_q[i].vld) begin
        free_ok  = 1'b1;
        free_idx = AW'(i);
      end
    vic_ok  = 1'b0;
    vic_idx = '0;
    vic_age = '0;
    for (int i = 0; i < N; i++)
      if (ent_q[i].vld && !ent_q[i].lck && (!vic_ok || age_q[i] > vic_age)) begin
        vic_ok  = 1'b1;
        vic_idx = AW'(i);
        vic_age = age_q[i];
      end
    tgt   = free_ok ? free_idx : vic_idx;
    do_wr = wr_i && (free_ok || vic_ok);
  end

  // age is a rank: 0 newest, distinct among valid entries
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) begin
        ent_q[i] <= '0;
        age_q[i] <= '0;
      end
      ovf_q <= 1'b0;
    end else begin
      if (do_wr) begin
        ent_q[tgt] <= wr_tte_i;
        age_q[tgt] <= '0;
        for (int i = 0; i < N; i++)
          if (AW'(i) != tgt && ent_q[i].vld && (free_ok || age_q[i] < age_q[tgt]))
            age_q[i] <= age_q[i] + 1'b1;
      end
      if (wr_i && !do_wr) ovf_q <= 1'b1;
    end
  end

  assign ovf_o = ovf_q;

  logic all_locked;
  always_comb begin
    all_locked = 1'b1;
    for (int i = 0; i < N; i++) all_locked &= ent_q[i].vld & ent_q[i].lck;
  end

  for (genvar g = 0; g < N; g++) begin : g_lock
    p_lock_kept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ent_q[g].vld && ent_q[g].lck) |=> $stable(ent_q[g]));
  end

  p_ovf_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && all_locked) |=> ovf_o);

  p_ovf_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);

  p_fa_route_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wr_tte_i.big) |-> wr_tte_i.lck);
endmodule

// File: rtl/xlt_sa.sv
module xlt_sa
  import xlt_pkg::*;
#(
  parameter int SETS = 16,
  parameter int WAYS = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VPN_W-1:0] lk_vpn_i,
  input  logic [CTX_W-1:0] lk_ctx_i,
  output logic             hit_o,
  output logic             multi_o,
  output tte_t             hit_tte_o,
  input  logic             wr_i,
  input  tte_t             wr_tte_i
);
  localparam int IW = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int WW = (WAYS > 1) ? $clog2(WAYS) : 1;

  tte_t          ent_q [SETS][WAYS];
  logic [WW-1:0] rr_q  [SETS];

  logic [IW-1:0] lset, wset;
  int            cnt;
  logic          free_ok;
  logic [WW-1:0] free_way, way;

  assign lset = lk_vpn_i[IW-1:0];
  assign wset = wr_tte_i.vpn[IW-1:0];

  always_comb begin
    cnt       = 0;
    hit_tte_o = '0;
    for (int w = 0; w < WAYS; w++)
      if (tte_match(ent_q[lset][w], lk_vpn_i, lk_ctx_i)) begin
        cnt++;
        hit_tte_o = ent_q[lset][w];
      end
    hit_o   = (cnt > 0);
    multi_o = (cnt > 1);
  end

  always_comb begin
    free_ok  = 1'b0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!ent_q[wset][w].vld) begin
        free_ok  = 1'b1;
        free_way = WW'(w);
      end
    way = free_ok ? free_way : rr_q[wset];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        rr_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) ent_q[s][w] <= '0;
      end
    end else if (wr_i) begin
      ent_q[wset][way] <= wr_tte_i;
      if (!free_ok) rr_q[wset] <= (rr_q[wset] == WW'(WAYS - 1)) ? '0 : rr_q[wset] + 1'b1;
    end
  end

  p_sa_small_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> (!wr_tte_i.big && !wr_tte_i.lck));
endmodule

// File: rtl/xlt_unit.sv
module xlt_unit
  import xlt_pkg::*;
#(
  parameter int UTLB_N  = 32,
  parameter int FA_N    = 8,
  parameter int SA_SETS = 16,
  parameter int SA_WAYS = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  lk_req_i,
  input  logic [VA_W-1:0]       lk_va_i,
  input  logic [CTX_W-1:0]      lk_ctx_i,
  output logic                  lk_rdy_o,
  input  logic                  wr_en_i,
  input  logic [VA_W-1:0]       wr_va_i,
  input  logic [CTX_W-1:0]      wr_ctx_i,
  input  logic [PA_FIELD_W-1:0] wr_pa_i,
  input  logic                  wr_big_i,
  input  logic                  wr_lock_i,
  output logic                  rsp_vld_o,
  output logic                  rsp_hit_o,
  output logic                  rsp_miss_o,
  output logic                  rsp_mhit_o,
  output logic [PA_FIELD_W-1:0] rsp_pa_o,
  output logic                  fa_ovf_o
);
  logic             pend_q;
  logic [VA_W-1:0]  pva_q;
  logic [CTX_W-1:0] pctx_q;

  tte_t wr_tte, u_tte, fa_tte, sa_tte, m_tte;
  logic u_hit, fa_hit, fa_multi, sa_hit, sa_multi;
  logic m_hit, m_multi, fill, acc, fa_wr, sa_wr;

  assign wr_tte = '{vld: 1'b1, lck: wr_lock_i, big: wr_big_i, ctx: wr_ctx_i,
                    vpn: wr_va_i[VA_W-1:SMALL_SH], ppn: wr_pa_i[PA_W-1:SMALL_SH]};
  assign fa_wr  = wr_en_i && (wr_lock_i || wr_big_i);
  assign sa_wr  = wr_en_i && !fa_wr;

  assign lk_rdy_o = !pend_q;
  assign acc      = lk_req_i && lk_rdy_o;

  xlt_utlb #(.N(UTLB_N)) u_utlb (
    .clk_i, .rst_ni,
    .lk_vpn_i(lk_va_i[VA_W-1:SMALL_SH]), .lk_ctx_i(lk_ctx_i),
    .hit_o(u_hit), .hit_tte_o(u_tte),
    .fill_i(fill), .fill_tte_i(m_tte),
    .inv_i(wr_en_i), .inv_vpn_i(wr_va_i[VA_W-1:SMALL_SH])
  );

  xlt_fa #(.N(FA_N)) u_fa (
    .clk_i, .rst_ni,
    .lk_vpn_i(pva_q[VA_W-1:SMALL_SH]), .lk_ctx_i(pctx_q),
    .hit_o(fa_hit), .multi_o(fa_multi), .hit_tte_o(fa_tte),
    .wr_i(fa_wr), .wr_tte_i(wr_tte), .ovf_o(fa_ovf_o)
  );

  xlt_sa #(.SETS(SA_SETS), .WAYS(SA_WAYS)) u_sa (
    .clk_i, .rst_ni,
    .lk_vpn_i(pva_q[VA_W-1:SMALL_SH]), .lk_ctx_i(pctx_q),
    .hit_o(sa_hit), .multi_o(sa_multi), .hit_tte_o(sa_tte),
    .wr_i(sa_wr), .wr_tte_i(wr_tte)
  );

  assign m_hit   = fa_hit | sa_hit;
  assign m_multi = fa_multi | sa_multi | (fa_hit & sa_hit);
  assign m_tte   = fa_hit ? fa_tte : sa_tte;
  // a write in the refill cycle wins over the refill
  assign fill    = pend_q && m_hit && !m_multi && !wr_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      pva_q      <= '0;
      pctx_q     <= '0;
      rsp_vld_o  <= 1'b0;
      rsp_hit_o  <= 1'b0;
      rsp_miss_o <= 1'b0;
      rsp_mhit_o <= 1'b0;
      rsp_pa_o   <= '0;
    end else begin
      rsp_vld_o  <= 1'b0;
      rsp_hit_o  <= 1'b0;
      rsp_miss_o <= 1'b0;
      rsp_mhit_o <= 1'b0;
      rsp_pa_o   <= '0;
      if (pend_q) begin
        pend_q     <= 1'b0;
        rsp_vld_o  <= 1'b1;
        rsp_hit_o  <= m_hit && !m_multi;
        rsp_mhit_o <= m_multi;
        rsp_miss_o <= !m_hit;
        if (m_hit && !m_multi) rsp_pa_o <= mk_pa(m_tte, pva_q);
      end else if (acc) begin
        if (u_hit) begin
          rsp_vld_o <= 1'b1;
          rsp_hit_o <= 1'b1;
          rsp_pa_o  <= mk_pa(u_tte, lk_va_i);
        end else begin
          pend_q <= 1'b1;
          pva_q  <= lk_va_i;
          pctx_q <= lk_ctx_i;
        end
      end
    end
  end

  p_uhit_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && u_hit) |=> (rsp_vld_o && rsp_hit_o && lk_rdy_o));

  p_umiss_lat_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !u_hit) |=> (!lk_rdy_o && !rsp_vld_o) ##1 rsp_vld_o);

  p_rsp_kind_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_vld_o |-> ($countones({rsp_hit_o, rsp_miss_o, rsp_mhit_o}) == 1));

  p_pa_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_vld_o && !rsp_hit_o) |-> (rsp_pa_o == '0));
endmodule

// File: tb/xlt_unit_test.sv
module xlt_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_req = 1'b0;
  logic [43:0] lk_va = '0;
  logic [12:0] lk_ctx = '0;
  logic        lk_rdy;
  logic        wr_en = 1'b0;
  logic [43:0] wr_va = '0;
  logic [12:0] wr_ctx = '0;
  logic [46:0] wr_pa = '0;
  logic        wr_big = 1'b0;
  logic        wr_lock = 1'b0;
  logic        rsp_vld, rsp_hit, rsp_miss, rsp_mhit, fa_ovf;
  logic [46:0] rsp_pa;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  xlt_unit uut (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_req_i(lk_req), .lk_va_i(lk_va), .lk_ctx_i(lk_ctx), .lk_rdy_o(lk_rdy),
    .wr_en_i(wr_en), .wr_va_i(wr_va), .wr_ctx_i(wr_ctx), .wr_pa_i(wr_pa),
    .wr_big_i(wr_big), .wr_lock_i(wr_lock),
    .rsp_vld_o(rsp_vld), .rsp_hit_o(rsp_hit), .rsp_miss_o(rsp_miss),
    .rsp_mhit_o(rsp_mhit), .rsp_pa_o(rsp_pa), .fa_ovf_o(fa_ovf)
  );

  localparam int K_HIT = 0, K_MISS = 1, K_MHIT = 2, K_NONE = 3;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [46:0] epa(input logic [46:0] pa, input logic [43:0] va, input bit big);
    return big ? {4'b0, pa[42:22], va[21:0]} : {4'b0, pa[42:13], va[12:0]};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; lk_req = 1'b0; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [43:0] va, input logic [12:0] ctx, input logic [46:0] pa,
                    input bit big, input bit lock);
    @(negedge clk);
    wr_en = 1'b1; wr_va = va; wr_ctx = ctx; wr_pa = pa; wr_big = big; wr_lock = lock;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(input logic [43:0] va, input logic [12:0] ctx, output int kind,
                      output logic [46:0] pa, output int lat, output bit rdy_low);
    @(negedge clk);
    lk_req = 1'b1; lk_va = va; lk_ctx = ctx;
    @(negedge clk);
    lk_req  = 1'b0;
    lat     = 1;
    rdy_low = 1'b0;
    if (!rsp_vld) begin
      rdy_low = !lk_rdy;
      @(negedge clk);
      lat = 2;
    end
    if (!rsp_vld) begin
      lat = 3; kind = K_NONE; pa = '0;
    end else begin
      kind = rsp_hit ? K_HIT : rsp_miss ? K_MISS : rsp_mhit ? K_MHIT : K_NONE;
      pa   = rsp_pa;
    end
  endtask

  task automatic expect_look(input string req, input logic [43:0] va, input logic [12:0] ctx,
                             input int ekind, input logic [46:0] epa_v, input int elat);
    int k, l;
    logic [46:0] p;
    bit rl;
    look(va, ctx, k, p, l, rl);
    chk({req, " kind"}, 64'(k), 64'(ekind));
    chk({req, " pa"}, 64'(p), 64'(epa_v));
    chk({req, " latency"}, 64'(l), 64'(elat));
    if (elat == 2) chk({req, " ready low on micro miss"}, 64'(rl), 64'd1);
  endtask

  // random phase model
  logic [43:0] pg_va [16];
  logic [46:0] pg_pa [16];
  bit          pg_seen [16];

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [43:0] a, b, c, e;
    logic [46:0] pa_a, pa_b;
    void'($urandom(32'd4242));

    // R1 reset state
    do_reset();
    chk("R1 ready after reset", 64'(lk_rdy), 64'd1);
    chk("R1 no response after reset", 64'(rsp_vld), 64'd0);
    chk("R1 overflow clear", 64'(fa_ovf), 64'd0);
    expect_look("R1 empty lookup", 44'h123_4567_8000, 13'd3, K_MISS, '0, 2);

    // random phase: one 8 KB page per set, R2 R3 R4 R11
    for (int s = 0; s < 16; s++) begin
      pg_va[s]   = {27'($urandom()), 4'(s), 13'h0};
      pg_pa[s]   = {4'hF, 30'($urandom()), 13'h0};
      pg_seen[s] = 1'b0;
      wr(pg_va[s], 13'd7, pg_pa[s], 1'b0, 1'b0);
    end
    for (int n = 0; n < 150; n++) begin
      int s;
      logic [43:0] va;
      s = int'($urandom_range(15, 0));
      if ($urandom_range(3, 0) != 0) begin
        va = pg_va[s] | 44'($urandom_range(8191, 0));
        expect_look(pg_seen[s] ? "R2 random micro hit" : "R3 random refill", va, 13'd7,
                    K_HIT, epa(pg_pa[s], va, 1'b0), pg_seen[s] ? 1 : 2);
        pg_seen[s] = 1'b1;
      end else begin
        va = pg_va[s] ^ 44'h800_0000_0000;
        expect_look("R4 random unmapped", va, 13'd7, K_MISS, '0, 2);
      end
    end

    // R3 R2 R11 R13 R4 directed
    do_reset();
    a = 44'h0AB_CDE0_2000; pa_a = 47'h7A5_5A5A_6000;
    wr(a, 13'd5, pa_a, 1'b0, 1'b0);
    expect_look("R3 refill from set part", a | 44'h123, 13'd5, K_HIT, epa(pa_a, a | 44'h123, 1'b0), 2);
    expect_look("R2 hit after refill", a | 44'h456, 13'd5, K_HIT, epa(pa_a, a | 44'h456, 1'b0), 1);
    chk("R11 upper pa bits zero", 64'(rsp_pa[46:43]), 64'd0);
    expect_look("R13 other context", a, 13'd6, K_MISS, '0, 2);
    expect_look("R4 unmapped first", 44'h0AB_CDE0_4000, 13'd5, K_MISS, '0, 2);
    expect_look("R4 unmapped no refill", 44'h0AB_CDE0_4000, 13'd5, K_MISS, '0, 2);

    // R7 + R5: rewrite page a (second way) -> micro copy removed, main multi-hit
    wr(a, 13'd5, 47'h1_2345_6000, 1'b0, 1'b0);
    expect_look("R7 R5 invalidated then multi-hit", a, 13'd5, K_MHIT, '0, 2);
    expect_look("R5 multi-hit not refilled", a, 13'd5, K_MHIT, '0, 2);

    // R6 shadow, R5 across parts, R11 large page
    do_reset();
    c = 44'h000_0180_6000;            // 8 KB page inside 4 MB region 6
    b = 44'h000_0180_A000;            // other 8 KB page of the same region
    e = 44'h000_0181_4000;            // third page of the region
    pa_a = 47'h0_0AAA_A000; pa_b = 47'h5_5540_0000;
    wr(c, 13'd1, pa_a, 1'b0, 1'b0);
    expect_look("R3 refill small", c, 13'd1, K_HIT, epa(pa_a, c, 1'b0), 2);
    wr(b, 13'd1, pa_b, 1'b1, 1'b0);
    expect_look("R6 micro hit not checked", c | 44'h10, 13'd1, K_HIT, epa(pa_a, c | 44'h10, 1'b0), 1);
    expect_look("R11 large page offset", e | 44'h1F0, 13'd1, K_HIT, epa(pa_b, e | 44'h1F0, 1'b1), 2);
    wr(c, 13'd1, pa_b, 1'b1, 1'b0);
    expect_look("R5 multi-hit across parts", c, 13'd1, K_MHIT, '0, 2);

    // R12 set replacement
    do_reset();
    for (int i = 0; i < 3; i++)
      wr(44'h000_0000_2000 + 44'(i) * 44'h2_0000, 13'd2, 47'(i + 1) << 13, 1'b0, 1'b0);
    expect_look("R12 round robin evicts way 0", 44'h000_0000_2000, 13'd2, K_MISS, '0, 2);
    expect_look("R12 third kept", 44'h000_0004_2000, 13'd2, K_HIT, 47'h0_0000_6000, 2);
    wr(44'h000_0006_2000, 13'd2, 47'h0_0000_8000, 1'b0, 1'b0);
    expect_look("R12 second evicted", 44'h000_0002_2000, 13'd2, K_MISS, '0, 2);
    expect_look("R12 micro copy kept", 44'h000_0004_2000, 13'd2, K_HIT, 47'h0_0000_6000, 1);
    expect_look("R12 fourth kept", 44'h000_0006_2000, 13'd2, K_HIT, 47'h0_0000_8000, 2);

    // R9 oldest unlocked replaced, R8 locked small goes to assoc part
    do_reset();
    wr(44'h000_0000_4000, 13'd1, 47'h0_0009_0000, 1'b0, 1'b1);
    for (int i = 1; i <= 8; i++)
      wr(44'(i) << 22, 13'd1, 47'(i) << 22, 1'b1, 1'b0);
    expect_look("R9 oldest unlocked gone", 44'(1) << 22, 13'd1, K_MISS, '0, 2);
    expect_look("R9 second kept", (44'(2) << 22) | 44'h5, 13'd1, K_HIT, (47'(2) << 22) | 47'h5, 2);
    expect_look("R9 locked kept", 44'h000_0000_4000, 13'd1, K_HIT, 47'h0_0009_0000, 2);
    expect_look("R9 newest present", 44'(8) << 22, 13'd1, K_HIT, 47'(8) << 22, 2);
    chk("R9 no overflow", 64'(fa_ovf), 64'd0);

    // R10 overflow, R8 routing
    do_reset();
    for (int i = 1; i <= 4; i++) wr(44'(i) << 13, 13'd4, 47'(i) << 13, 1'b0, 1'b1);
    for (int i = 10; i <= 13; i++) wr(44'(i) << 22, 13'd4, 47'(i) << 22, 1'b1, 1'b1);
    chk("R8 locked entries fit", 64'(fa_ovf), 64'd0);
    wr(44'h000_0004_0000, 13'd4, 47'h0_0004_0000, 1'b0, 1'b0);
    chk("R8 small unlocked to set part", 64'(fa_ovf), 64'd0);
    expect_look("R8 small unlocked present", 44'h000_0004_0000, 13'd4, K_HIT, 47'h0_0004_0000, 2);
    wr(44'(20) << 22, 13'd4, 47'(20) << 22, 1'b1, 1'b0);
    chk("R10 overflow set", 64'(fa_ovf), 64'd1);
    expect_look("R10 dropped entry absent", 44'(20) << 22, 13'd4, K_MISS, '0, 2);
    expect_look("R10 locked entry intact", 44'(10) << 22, 13'd4, K_HIT, 47'(10) << 22, 2);
    expect_look("R8 locked small in assoc part", 44'h000_0000_2000, 13'd4, K_HIT, 47'h0_0000_2000, 2);
    wr(44'h000_0008_0000, 13'd4, 47'h0_0008_0000, 1'b0, 1'b0);
    chk("R10 overflow sticky", 64'(fa_ovf), 64'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule